// File: doc/BRIEF.md
# Banked Inbound Packet Buffer

This block holds packets that arrive on a host-side inbound data pipe until the local processor has read them. A bus-side write port streams bytes into the bank currently being filled. A strobe marks the end of each packet, and an error strobe sent with it marks the packet as corrupted. The block can be built with one bank or with two. With two banks, the bus side fills one bank while the processor drains the other, and the banks alternate starting from bank 0.

The processor reaches the block through a small register port with four registers: status, control, byte count and data. Reading the data register steps through the bytes of the bank that the processor currently holds. Two status flags drive the handshake, and hardware can only set them while software can only clear them. The first is a "received" flag, which raises the receive interrupt when that interrupt is enabled. Clearing it acknowledges the interrupt and does nothing else. The second is an "owned" flag. Clearing it returns the bank to the bus side and moves the processor to the next bank. Hardware then reloads both flags from the state of that next bank. A third flag records corrupted packets and drives a separate error interrupt.

Top module: `rx_pipe_buf`

## Requirements
- R1: After reset, the status register (address 0) reads 0, the control register (address 1) reads 0, and `bus_no_bank`, `rx_irq` and `err_irq` are low.
- R2: When a packet ends into the bank the processor holds, status bit 0 (received) and bit 1 (owned) both read 1 from the next cycle, and the count register (address 2) holds the number of bytes stored.
- R3: `rx_irq` is high exactly when the received flag is 1 and control bit 0 is 1.
- R4: Writing status with bit 0 at 0 clears the received flag and lowers `rx_irq`. The owned flag, the byte count and the stored data are unchanged.
- R5: Writing status with bit 1 at 0 while the owned flag is 1 frees the bank and restarts the data read position at byte 0. It also moves the processor to the next bank, and status bit 3 shows the bank index. Both flags then equal 1 if that bank already holds a finished packet and 0 otherwise.
- R6: Each read of the data register (address 3) returns the next stored byte of the held bank in arrival order.
- R7: With two banks, packets fill bank 0, then bank 1, then bank 0 again. Bank 1 accepts a packet while bank 0 is still held.
- R8: `bus_no_bank` is high while the bank being filled still holds an unreleased packet. Bytes and packet ends offered during that time are discarded.
- R9: A packet that ends with `bus_crc_err` high while control bit 2 (error capture) is 1 sets status bit 2, and `err_irq` follows it when control bit 1 is 1. The received flag is still set for that packet. With control bit 2 at 0 the error flag stays 0. Writing status bit 2 as 0 clears it.
- R10: Writing 1 to status bits 0, 1 or 2 never sets them. Writing bit 1 as 0 while the owned flag is 0 changes nothing.
- R11: With one bank, the bank index stays 0, and after a release the same bank accepts the next packet.
- R12: Bytes beyond the bank capacity are dropped. The count then equals the capacity and the first capacity bytes are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_valid | input | 1 | Byte present on `bus_wr_data` |
| bus_wr_data | input | DATA_W | Incoming packet byte |
| bus_pkt_end | input | 1 | Current packet is complete (may coincide with its last byte) |
| bus_crc_err | input | 1 | Packet that ends this cycle is corrupted |
| bus_no_bank | output | 1 | No free bank; bus side must hold off |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe (advances the data pointer at address 3) |
| cpu_addr | input | 2 | Register address |
| cpu_wdata | input | DATA_W | Register write data |
| cpu_rdata | output | DATA_W | Register read data, combinational from `cpu_addr` |
| rx_irq | output | 1 | Receive interrupt |
| err_irq | output | 1 | Corrupted-packet interrupt |

## Verification
The assertions rely on the error strobe being meaningful only in the cycle that carries a packet end. They also rely on the processor issuing at most one register access per cycle. The bench raises `bus_crc_err` only alongside `bus_pkt_end` and never overlaps a register write with a data read. The assertions place no condition on bus traffic while no bank is free. The bench deliberately sends a whole packet in that state and then confirms, once the bank is released, that the data read back is unchanged.

// File: rtl/rx_pipe_pkg.sv
package rx_pipe_pkg;
    localparam int BANK_SLOTS = 2;

    typedef enum logic [1:0] {
        RA_STATUS = 2'd0,
        RA_CTRL   = 2'd1,
        RA_COUNT  = 2'd2,
        RA_DATA   = 2'd3
    } reg_addr_e;

    localparam int ST_RXIN  = 0;
    localparam int ST_OWN   = 1;
    localparam int ST_ERR   = 2;
    localparam int ST_BANK  = 3;

    localparam int CT_RXIE  = 0;
    localparam int CT_ERRIE = 1;
    localparam int CT_ISO   = 2;
endpackage

// File: rtl/rx_bank_mem.sv
module rx_bank_mem #(
    parameter int NUM_BANKS = 2,
    parameter int DEPTH     = 16,
    parameter int DW        = 8,
    parameter int IDX_W     = 4
) (
    input  logic             clk,
    input  logic             we,
    input  logic             wbank,
    input  logic [IDX_W-1:0] widx,
    input  logic [DW-1:0]    wdata,
    input  logic             rbank,
    input  logic [IDX_W-1:0] ridx,
    output logic [DW-1:0]    rdata
);
    logic [DW-1:0] bank_rd [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [DW-1:0] store [DEPTH];
        always_ff @(posedge clk) begin
            if (we && (wbank == 1'(b))) store[widx] <= wdata;
        end
        assign bank_rd[b] = store[ridx];
    end

    always_comb begin
        if ((NUM_BANKS > 1) && rbank) rdata = bank_rd[NUM_BANKS-1];
        else                          rdata = bank_rd[0];
    end
endmodule

// File: rtl/rx_fill_ctrl.sv
module rx_fill_ctrl
    import rx_pipe_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int DEPTH     = 16,
    parameter int IDX_W     = 4,
    parameter int CNT_W     = 5
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_valid,
    input  logic                               pkt_end,
    input  logic                               rel_en,
    input  logic                               rel_bank,
    output logic                               mem_we,
    output logic [IDX_W-1:0]                   mem_idx,
    output logic                               fill_bank,
    output logic [BANK_SLOTS-1:0]              full_o,
    output logic [BANK_SLOTS-1:0][CNT_W-1:0]   cnt_o,
    output logic                               done_o,
    output logic                               no_bank_o
);
    localparam logic MULTI = (NUM_BANKS > 1);

    typedef struct packed {
        logic                             ptr;
        logic [CNT_W-1:0]                 wcnt;
        logic [BANK_SLOTS-1:0]            full;
        logic [BANK_SLOTS-1:0][CNT_W-1:0] cnt;
    } fill_t;

    fill_t s_d, s_q;
    logic cur_full_d;
    logic room_d;
    logic [CNT_W-1:0] len_d;

    always_comb begin
        s_d        = s_q;
        cur_full_d = s_q.full[s_q.ptr];
        room_d     = (s_q.wcnt < CNT_W'(DEPTH));
        mem_we     = wr_valid && !cur_full_d && room_d;
        done_o     = pkt_end && !cur_full_d;
        len_d      = s_q.wcnt + (mem_we ? CNT_W'(1) : CNT_W'(0));
        if (mem_we) s_d.wcnt = len_d;
        if (rel_en) s_d.full[rel_bank] = 1'b0;
        if (done_o) begin
            s_d.full[s_q.ptr] = 1'b1;
            s_d.cnt[s_q.ptr]  = len_d;
            s_d.wcnt          = '0;
            s_d.ptr           = MULTI ? ~s_q.ptr : 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mem_idx   = s_q.wcnt[IDX_W-1:0];
    assign fill_bank = s_q.ptr;
    assign full_o    = s_q.full;
    assign cnt_o     = s_q.cnt;
    assign no_bank_o = cur_full_d;

    // R12
    count_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.wcnt <= CNT_W'(DEPTH));

    // R7
    fill_ptr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.ptr) |-> $past(done_o));

    for (genvar b = 0; b < BANK_SLOTS; b++) begin : g_hold
        // R8
        bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (s_q.full[b] && !(rel_en && (rel_bank == 1'(b)))) |=> s_q.full[b]);
    end
endmodule

// File: rtl/rx_cpu_ctrl.sv
module rx_cpu_ctrl
    import rx_pipe_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int DW        = 8,
    parameter int IDX_W     = 4,
    parameter int CNT_W     = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_wr,
    input  logic                  cpu_rd,
    input  logic [1:0]            cpu_addr,
    input  logic [DW-1:0]         cpu_wdata,
    input  logic [BANK_SLOTS-1:0] full_q,
    input  logic                  done,
    input  logic                  done_bank,
    input  logic                  done_err,
    input  logic [CNT_W-1:0]      cnt_cur,
    input  logic [DW-1:0]         mem_rdata,
    output logic [DW-1:0]         cpu_rdata,
    output logic                  rx_irq,
    output logic                  err_irq,
    output logic                  rel_o,
    output logic                  bank_o,
    output logic [IDX_W-1:0]      ridx_o
);
    localparam logic MULTI = (NUM_BANKS > 1);

    typedef struct packed {
        logic             ptr;
        logic [IDX_W-1:0] ridx;
        logic             rxin;
        logic             own;
        logic             err;
        logic             rx_ie;
        logic             err_ie;
        logic             iso;
    } cpu_t;

    cpu_t s_d, s_q;
    reg_addr_e addr;
    logic wr_stat, wr_ctrl, pop, rel, hit, nxt, nxt_full;
    logic unused_wbits;

    assign unused_wbits = ^cpu_wdata;

    always_comb begin
        s_d      = s_q;
        addr     = reg_addr_e'(cpu_addr);
        wr_stat  = cpu_wr && (addr == RA_STATUS);
        wr_ctrl  = cpu_wr && (addr == RA_CTRL);
        pop      = cpu_rd && (addr == RA_DATA);
        rel      = wr_stat && !cpu_wdata[ST_OWN] && s_q.own;
        hit      = done && (done_bank == s_q.ptr);
        nxt      = MULTI ? ~s_q.ptr : 1'b0;
        nxt_full = ((nxt != s_q.ptr) && full_q[nxt]) || (done && (done_bank == nxt));
        if (rel) begin
            s_d.ptr  = nxt;
            s_d.ridx = '0;
            s_d.own  = nxt_full;
            s_d.rxin = nxt_full;
        end else begin
            if (wr_stat && !cpu_wdata[ST_RXIN]) s_d.rxin = 1'b0;
            if (hit) begin
                s_d.rxin = 1'b1;
                s_d.own  = 1'b1;
            end
            if (pop) s_d.ridx = s_q.ridx + IDX_W'(1);
        end
        if (wr_stat && !cpu_wdata[ST_ERR]) s_d.err = 1'b0;
        if (done && done_err && s_q.iso)   s_d.err = 1'b1;
        if (wr_ctrl) begin
            s_d.rx_ie  = cpu_wdata[CT_RXIE];
            s_d.err_ie = cpu_wdata[CT_ERRIE];
            s_d.iso    = cpu_wdata[CT_ISO];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        unique case (addr)
            RA_STATUS: cpu_rdata = DW'({s_q.ptr, s_q.err, s_q.own, s_q.rxin});
            RA_CTRL:   cpu_rdata = DW'({s_q.iso, s_q.err_ie, s_q.rx_ie});
            RA_COUNT:  cpu_rdata = DW'(cnt_cur);
            default:   cpu_rdata = mem_rdata;
        endcase
    end

    assign rx_irq  = s_q.rxin && s_q.rx_ie;
    assign err_irq = s_q.err && s_q.err_ie;
    assign rel_o   = rel;
    assign bank_o  = s_q.ptr;
    assign ridx_o  = s_q.ridx;

    // R2
    own_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.own) |-> $past(hit || rel));

    // R10
    rxin_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.rxin) |-> $past(hit || rel));

    // R5
    read_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel |=> (s_q.ridx == '0) && (s_q.rxin == s_q.own));

    // R11
    single_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !MULTI |-> !s_q.ptr);
endmodule

// File: rtl/rx_pipe_buf.sv
module rx_pipe_buf
    import rx_pipe_pkg::*;
#(
    parameter int NUM_BANKS  = 2,
    parameter int BANK_BYTES = 16,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_valid,
    input  logic [DATA_W-1:0] bus_wr_data,
    input  logic              bus_pkt_end,
    input  logic              bus_crc_err,
    output logic              bus_no_bank,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [1:0]        cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              rx_irq,
    output logic              err_irq
);
    localparam int IDX_W = $clog2(BANK_BYTES);
    localparam int CNT_W = $clog2(BANK_BYTES + 1);

    logic                             mem_we, fill_bank, done, rel, cpu_bank;
    logic [IDX_W-1:0]                 mem_idx, ridx;
    logic [BANK_SLOTS-1:0]            full;
    logic [BANK_SLOTS-1:0][CNT_W-1:0] cnt;
    logic [DATA_W-1:0]                mem_rdata;

    rx_fill_ctrl #(.NUM_BANKS(NUM_BANKS), .DEPTH(BANK_BYTES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_fill (
        .clk(clk), .rst_n(rst_n), .wr_valid(bus_wr_valid), .pkt_end(bus_pkt_end),
        .rel_en(rel), .rel_bank(cpu_bank), .mem_we(mem_we), .mem_idx(mem_idx),
        .fill_bank(fill_bank), .full_o(full), .cnt_o(cnt), .done_o(done),
        .no_bank_o(bus_no_bank)
    );

    rx_bank_mem #(.NUM_BANKS(NUM_BANKS), .DEPTH(BANK_BYTES), .DW(DATA_W), .IDX_W(IDX_W)) u_mem (
        .clk(clk), .we(mem_we), .wbank(fill_bank), .widx(mem_idx), .wdata(bus_wr_data),
        .rbank(cpu_bank), .ridx(ridx), .rdata(mem_rdata)
    );

    rx_cpu_ctrl #(.NUM_BANKS(NUM_BANKS), .DW(DATA_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_cpu (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .full_q(full), .done(done), .done_bank(fill_bank),
        .done_err(bus_crc_err), .cnt_cur(cnt[cpu_bank]), .mem_rdata(mem_rdata),
        .cpu_rdata(cpu_rdata), .rx_irq(rx_irq), .err_irq(err_irq), .rel_o(rel),
        .bank_o(cpu_bank), .ridx_o(ridx)
    );
endmodule

// File: tb/rx_pipe_buf_bench.sv
module rx_pipe_buf_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr_valid = 1'b0, bus_pkt_end = 1'b0, bus_crc_err = 1'b0;
    logic [7:0] bus_wr_data = '0;
    logic cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [1:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] rdata_a, rdata_b;
    logic nob_a, nob_b, rxi_a, rxi_b, eri_a, eri_b;
    int errs = 0;
    int total = 0;

    always #10 clk = ~clk;

    rx_pipe_buf #(.NUM_BANKS(2), .BANK_BYTES(16), .DATA_W(8)) u_rx_pipe_buf (
        .clk(clk), .rst_n(rst_n), .bus_wr_valid(bus_wr_valid), .bus_wr_data(bus_wr_data),
        .bus_pkt_end(bus_pkt_end), .bus_crc_err(bus_crc_err), .bus_no_bank(nob_a),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(rdata_a), .rx_irq(rxi_a), .err_irq(eri_a));

    rx_pipe_buf #(.NUM_BANKS(1), .BANK_BYTES(16), .DATA_W(8)) u_rx_pipe_buf_one (
        .clk(clk), .rst_n(rst_n), .bus_wr_valid(bus_wr_valid), .bus_wr_data(bus_wr_data),
        .bus_pkt_end(bus_pkt_end), .bus_crc_err(bus_crc_err), .bus_no_bank(nob_b),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(rdata_b), .rx_irq(rxi_b), .err_irq(eri_b));

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output int va, output int vb);
        cpu_addr = a;
        #1;
        va = int'(rdata_a);
        vb = int'(rdata_b);
    endtask

    task automatic pop(output int va, output int vb);
        cpu_addr = 2'd3; cpu_rd = 1'b1;
        #1;
        va = int'(rdata_a);
        vb = int'(rdata_b);
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic send(input int n, input int base, input logic err);
        for (int i = 0; i < n; i++) begin
            bus_wr_valid = 1'b1;
            bus_wr_data  = 8'(base + i);
            @(negedge clk);
        end
        bus_wr_valid = 1'b0;
        bus_pkt_end  = 1'b1;
        bus_crc_err  = err;
        @(negedge clk);
        bus_pkt_end  = 1'b0;
        bus_crc_err  = 1'b0;
    endtask

    function automatic int st(input int rxin, input int own, input int err, input int bank);
        return rxin + 2 * own + 4 * err + 8 * bank;
    endfunction

    task automatic read_block(input string req, input int n, input int base, input logic use_b);
        int va, vb;
        for (int i = 0; i < n; i++) begin
            pop(va, vb);
            check(req, use_b ? vb : va, (base + i) % 256);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++; total++;
        $display("FAIL watchdog (run) actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, total);
        $finish;
    end

    initial begin
        int va, vb;
        do_reset();
        // R1 reset state
        peek(2'd0, va, vb); check("R1 status", va, 0);
        peek(2'd1, va, vb); check("R1 ctrl", va, 0);
        check("R1 no_bank", int'(nob_a), 0);
        check("R1 irqs", int'({rxi_a, eri_a}), 0);

        // R2 first packet into bank 0
        send(5, 'h10, 1'b0);
        peek(2'd0, va, vb); check("R2 status", va, st(1, 1, 0, 0));
        peek(2'd2, va, vb); check("R2 count", va, 5);
        check("R7 bank1 free", int'(nob_a), 0);
        check("R3 irq masked", int'(rxi_a), 0);
        reg_write(2'd1, 8'h01);
        check("R3 irq enabled", int'(rxi_a), 1);

        // R7 bank 1 fills while bank 0 held
        send(16, 'h40, 1'b0);
        check("R8 no_bank", int'(nob_a), 1);
        // R8 packet offered with no free bank is discarded
        send(4, 'hA0, 1'b0);
        peek(2'd0, va, vb); check("R8 status", va, st(1, 1, 0, 0));
        peek(2'd2, va, vb); check("R8 count", va, 5);

        // R4 acknowledge only
        reg_write(2'd0, 8'h06);
        peek(2'd0, va, vb); check("R4 status", va, st(0, 1, 0, 0));
        check("R4 irq", int'(rxi_a), 0);
        peek(2'd2, va, vb); check("R4 count", va, 5);
        // R10 ones do not set flags
        reg_write(2'd0, 8'h07);
        peek(2'd0, va, vb); check("R10 set ignored", va, st(0, 1, 0, 0));

        // R6 ordered reads
        read_block("R6 data", 5, 'h10, 1'b0);

        // R5 release, switch to full bank 1
        reg_write(2'd0, 8'h05);
        peek(2'd0, va, vb); check("R5 switch status", va, st(1, 1, 0, 1));
        peek(2'd2, va, vb); check("R5 count", va, 16);
        check("R3 irq reload", int'(rxi_a), 1);
        check("R8 freed", int'(nob_a), 0);
        read_block("R7 bank1 data", 16, 'h40, 1'b0);

        // R5 release to empty bank 0
        reg_write(2'd0, 8'h05);
        peek(2'd0, va, vb); check("R5 empty reload", va, st(0, 0, 0, 0));
        // R10 release with nothing owned
        reg_write(2'd0, 8'h00);
        peek(2'd0, va, vb); check("R10 no switch", va, st(0, 0, 0, 0));

        // R12 overlong packet
        send(20, 'h80, 1'b0);
        peek(2'd0, va, vb); check("R2 status again", va, st(1, 1, 0, 0));
        peek(2'd2, va, vb); check("R12 count", va, 16);
        read_block("R12 data", 16, 'h80, 1'b0);

        // R9 error capture
        reg_write(2'd1, 8'h07);
        reg_write(2'd0, 8'h05);
        peek(2'd0, va, vb); check("R5 bank1 empty", va, st(0, 0, 0, 1));
        send(3, 'h30, 1'b1);
        peek(2'd0, va, vb); check("R9 status", va, st(1, 1, 1, 1));
        check("R9 err_irq", int'(eri_a), 1);
        check("R9 rx_irq", int'(rxi_a), 1);
        reg_write(2'd0, 8'h03);
        peek(2'd0, va, vb); check("R9 err cleared", va, st(1, 1, 0, 1));
        check("R9 err_irq low", int'(eri_a), 0);
        reg_write(2'd1, 8'h03);
        send(2, 'h50, 1'b1);
        peek(2'd0, va, vb); check("R9 no capture", va, st(1, 1, 0, 1));
        check("R9 err_irq off", int'(eri_a), 0);
        reg_write(2'd0, 8'h05);
        peek(2'd0, va, vb); check("R5 reload full", va, st(1, 1, 0, 0));
        peek(2'd2, va, vb); check("R5 count bank0", va, 2);
        read_block("R7 bank0 data", 2, 'h50, 1'b0);

        // R11 single bank configuration
        do_reset();
        send(2, 'h60, 1'b0);
        peek(2'd0, va, vb); check("R11 status", vb, st(1, 1, 0, 0));
        check("R11 no_bank", int'(nob_b), 1);
        send(2, 'h70, 1'b0);
        reg_write(2'd0, 8'h05);
        peek(2'd0, va, vb); check("R11 stay bank0", vb, st(0, 0, 0, 0));
        check("R11 bank free", int'(nob_b), 0);
        send(3, 'h20, 1'b0);
        peek(2'd0, va, vb); check("R11 refill", vb, st(1, 1, 0, 0));
        peek(2'd2, va, vb); check("R11 count", vb, 3);
        read_block("R11 data", 3, 'h20, 1'b1);

        $display("Result: errors=%0d of %0d checks", errs, total);
        $finish;
    end
endmodule